// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a high-rate input clock by N = B·P + A. It steers a dual-modulus prescaler that divides by P or P+1, and it counts the prescaler's cycles with a B counter and an A counter. In each output period the prescaler runs at P+1 for the first A of its cycles and at P for the remaining B−A. The block then gives a one-clock pulse and starts the next period. Inside the block the prescaler is a small counter clocked by the input clock. A two-bit code sets P to 8, 16, 32 or 64.

B, A and the prescaler code are checked on every clock. A setting with B below 3, or with B below A, raises an error flag, and the divider keeps the last legal setting. Legal settings are held, and the counters load them only at the end of a period, so a period never mixes two settings. A counter-reset input holds the counters at their load values until it is released. Every value of N can be reached only when N is at least P²−P. The block does not enforce that bound: it is a planning rule for the loop.

Top module: `swallow_divider`

## Requirements
- R1: With legal held values, the distance between successive `div_o` pulses is exactly B·P + A input clocks.
- R2: The prescaler code sets P: code 0 gives 8, code 1 gives 16, code 2 gives 32, code 3 gives 64.
- R3: `div_o` is high for exactly one input clock per period.
- R4: `mod_ctl_o` is high for the first A·(P+1) input clocks of each period and low for the rest. The period begins with the clock in which `div_o` is high.
- R5: With A = 0, `mod_ctl_o` stays low for the whole period. With A = B, it stays high for the whole period.
- R6: While `cnt_rst_i` is high, `div_o` stays low and the counters hold their load values, so `mod_ctl_o` is high exactly when the held A is nonzero. After release, the first `div_o` pulse is seen after the N-th rising edge.
- R7: When `b_val_i` < 3, `cfg_err_o` goes high one clock later and the divider keeps running with the last legal B, A and P.
- R8: When `b_val_i` < `a_val_i`, `cfg_err_o` goes high one clock later and the last legal setting is kept.
- R9: A new legal setting does not change the period in progress. It applies from the period that starts at the next `div_o` pulse.
- R10: During asynchronous reset, `div_o`, `mod_ctl_o` and `cfg_err_o` are low. The held setting resets to B=3, A=0, P=8 (N=24).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock (the prescaler input) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_rst_i | input | 1 | Synchronous counter reset; holds the counters at their load values |
| b_val_i | input | 13 | B, the count of prescaler cycles per period |
| a_val_i | input | 6 | A, the count of P+1 cycles per period |
| psel_i | input | 2 | Prescaler code (0:8, 1:16, 2:32, 3:64) |
| mod_ctl_o | output | 1 | Modulus control; high selects P+1 |
| div_o | output | 1 | One-clock pulse per output period |
| cfg_err_o | output | 1 | The current B/A inputs are illegal |

## Verification
The counter assertions rely on the guard: the held B is at least 3 and at least the held A, which keeps the remaining-A count at or below the remaining-B count. They also rely on P changing only at a prescaler wrap, so the prescaler count stays within its modulus. The inputs are unconstrained, because the guard filters them. The bench changes settings only at the falling edge of the clock where `div_o` is high, so every measured interval starts at a known period boundary. It keeps B small enough that each sweep point costs only a few hundred clocks.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
  localparam int PC_W = 7;  // holds modulus-1 up to 64

  typedef enum logic [1:0] {PSEL_8, PSEL_16, PSEL_32, PSEL_64} psel_e;

  function automatic logic [PC_W-1:0] base_of(psel_e code);
    case (code)
      PSEL_8:  return PC_W'(8);
      PSEL_16: return PC_W'(16);
      PSEL_32: return PC_W'(32);
      default: return PC_W'(64);
    endcase
  endfunction
endpackage

// File: rtl/swallow_cfg_guard.sv
module swallow_cfg_guard
  import swallow_pkg::*;
#(
  parameter int B_W   = 13,
  parameter int A_W   = 6,
  parameter int B_MIN = 3,
  parameter int B_RST = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [B_W-1:0] b_i,
  input  logic [A_W-1:0] a_i,
  input  psel_e          psel_i,
  output logic [B_W-1:0] hold_b_o,
  output logic [A_W-1:0] hold_a_o,
  output psel_e          hold_p_o,
  output logic           err_o
);
  localparam int AX = B_W - A_W;

  logic valid;
  assign valid = (b_i >= B_W'(B_MIN)) && (b_i >= {{AX{1'b0}}, a_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_b_o <= B_W'(B_RST);
      hold_a_o <= '0;
      hold_p_o <= PSEL_8;
      err_o    <= 1'b0;
    end else begin
      err_o <= !valid;
      if (valid) begin
        hold_b_o <= b_i;
        hold_a_o <= a_i;
        hold_p_o <= psel_i;
      end
    end
  end

  // R7 / R8: an illegal request leaves the held setting untouched
  a_r7_hold_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid |=> ($stable(hold_b_o) && $stable(hold_a_o) && $stable(hold_p_o)));

  a_r8_held_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_b_o >= B_W'(B_MIN)) && (hold_b_o >= {{AX{1'b0}}, hold_a_o}));

  a_r7_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_i < B_W'(B_MIN)) |=> err_o);
endmodule

// File: rtl/swallow_prescaler.sv
module swallow_prescaler
  import swallow_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [PC_W-1:0] base_i,
  input  logic            plus1_i,
  output logic            tick_o
);
  logic [PC_W-1:0] cnt;
  logic [PC_W-1:0] last;

  assign last   = plus1_i ? base_i : base_i - PC_W'(1);
  assign tick_o = (cnt == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt <= '0;
    else if (clr_i)   cnt <= '0;
    else if (tick_o)  cnt <= '0;
    else              cnt <= cnt + PC_W'(1);
  end

  // R2: count never passes the largest modulus for the active P
  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= base_i);

  a_r2_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt == '0));
endmodule

// File: rtl/swallow_counters.sv
module swallow_counters
  import swallow_pkg::*;
#(
  parameter int B_W   = 13,
  parameter int A_W   = 6,
  parameter int B_RST = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            tick_i,
  input  logic [B_W-1:0]  hold_b_i,
  input  logic [A_W-1:0]  hold_a_i,
  input  psel_e           hold_p_i,
  output logic [PC_W-1:0] p_act_o,
  output logic            mc_o,
  output logic            div_o
);
  localparam int AX = B_W - A_W;

  logic [B_W-1:0] b_rem;
  logic [A_W-1:0] a_rem;
  logic           reload;

  assign reload = tick_i && (b_rem == B_W'(1));
  assign mc_o   = (a_rem != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_rem   <= B_W'(B_RST);
      a_rem   <= '0;
      p_act_o <= base_of(PSEL_8);
      div_o   <= 1'b0;
    end else if (clr_i || reload) begin
      b_rem   <= hold_b_i;
      a_rem   <= hold_a_i;
      p_act_o <= base_of(hold_p_i);
      div_o   <= reload && !clr_i;
    end else begin
      div_o <= 1'b0;
      if (tick_i) begin
        b_rem <= b_rem - B_W'(1);
        if (a_rem != '0) a_rem <= a_rem - A_W'(1);
      end
    end
  end

  a_r1_b_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_rem != '0);

  // R4: swallow count drains before the period ends
  a_r4_a_le_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {{AX{1'b0}}, a_rem} <= b_rem);

  a_r4_mc_falls_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(mc_o) && !$past(clr_i)) |-> $past(tick_i));

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);

  a_r6_clr_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !div_o);
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swallow_pkg::*;
#(
  parameter int B_W   = 13,
  parameter int A_W   = 6,
  parameter int B_MIN = 3,
  parameter int B_RST = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cnt_rst_i,
  input  logic [B_W-1:0] b_val_i,
  input  logic [A_W-1:0] a_val_i,
  input  logic [1:0]     psel_i,
  output logic           mod_ctl_o,
  output logic           div_o,
  output logic           cfg_err_o
);
  logic [B_W-1:0]  hold_b;
  logic [A_W-1:0]  hold_a;
  psel_e           hold_p;
  logic [PC_W-1:0] p_act;
  logic            tick;

  swallow_cfg_guard #(
    .B_W(B_W), .A_W(A_W), .B_MIN(B_MIN), .B_RST(B_RST)
  ) u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .b_i      (b_val_i),
    .a_i      (a_val_i),
    .psel_i   (psel_e'(psel_i)),
    .hold_b_o (hold_b),
    .hold_a_o (hold_a),
    .hold_p_o (hold_p),
    .err_o    (cfg_err_o)
  );

  swallow_prescaler u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_rst_i),
    .base_i  (p_act),
    .plus1_i (mod_ctl_o),
    .tick_o  (tick)
  );

  swallow_counters #(
    .B_W(B_W), .A_W(A_W), .B_RST(B_RST)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cnt_rst_i),
    .tick_i   (tick),
    .hold_b_i (hold_b),
    .hold_a_i (hold_a),
    .hold_p_i (hold_p),
    .p_act_o  (p_act),
    .mc_o     (mod_ctl_o),
    .div_o    (div_o)
  );

  a_r10_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!div_o && !cfg_err_o && !mod_ctl_o));
endmodule

// File: tb/swallow_divider_test.sv
module swallow_divider_test;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        cnt_rst;
  logic [12:0] b_val;
  logic [5:0]  a_val;
  logic [1:0]  psel;
  logic        mod_ctl, div, cfg_err;

  int n_tests = 0;
  int n_fail  = 0;
  int cur_n   = 0;

  always #5 clk = ~clk;

  swallow_divider uut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .cnt_rst_i (cnt_rst),
    .b_val_i   (b_val),
    .a_val_i   (a_val),
    .psel_i    (psel),
    .mod_ctl_o (mod_ctl),
    .div_o     (div),
    .cfg_err_o (cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // precondition: at a falling edge where div is high
  task automatic measure(output int per, output int mcc);
    per = 0;
    mcc = 0;
    do begin
      if (mod_ctl) mcc++;
      per++;
      @(negedge clk);
    end while (!div);
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div);
  endtask

  task automatic run_cfg(input int b, input int a, input int code, input string tag);
    int per, mcc, p, nn;
    p  = 8 << code;
    nn = b * p + a;
    b_val = 13'(b);
    a_val = 6'(a);
    psel  = 2'(code);
    measure(per, mcc);
    chk(per == cur_n, "R9 old period kept", per, cur_n);
    measure(per, mcc);
    chk(per == nn, tag, per, nn);
    chk(mcc == a * (p + 1), "R4 modulus-control width", mcc, a * (p + 1));
    if (a == 0) chk(mcc == 0, "R5 A=0 never P+1", mcc, 0);
    if (a == b) chk(mcc == nn, "R5 A=B always P+1", mcc, nn);
    cur_n = nn;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int per, mcc, bad;
    rst_ni  = 1'b0;
    cnt_rst = 1'b0;
    b_val   = '0;
    a_val   = '0;
    psel    = 2'd2;
    repeat (3) @(negedge clk);
    chk(div == 0, "R10 div low in reset", div, 0);
    chk(cfg_err == 0, "R10 err low in reset", cfg_err, 0);
    chk(mod_ctl == 0, "R10 mod_ctl low in reset", mod_ctl, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cfg_err == 1, "R7 B=0 flagged", cfg_err, 1);
    wait_pulse();
    measure(per, mcc);
    chk(per == 24, "R10 default N", per, 24);
    chk(mcc == 0, "R10 default A", mcc, 0);
    cur_n = 24;

    // sweep with P=8
    for (int b = 3; b <= 12; b++)
      for (int a = 0; a <= b; a++)
        run_cfg(b, a, 0, "R1 ratio B*P+A");

    // other prescaler codes
    for (int c = 1; c <= 3; c++)
      for (int b = 3; b <= 5; b++) begin
        run_cfg(b, 0, c, "R2 prescaler code");
        run_cfg(b, 1, c, "R2 prescaler code");
        run_cfg(b, b, c, "R2 prescaler code");
      end

    // illegal settings
    run_cfg(7, 3, 0, "R1 ratio B*P+A");
    b_val = 13'd2;
    a_val = 6'd0;
    @(negedge clk);
    chk(cfg_err == 1, "R7 B<3 flagged", cfg_err, 1);
    wait_pulse();
    measure(per, mcc);
    chk(per == 59, "R7 previous setting kept", per, 59);
    b_val = 13'd4;
    a_val = 6'd5;
    @(negedge clk);
    chk(cfg_err == 1, "R8 B<A flagged", cfg_err, 1);
    wait_pulse();
    measure(per, mcc);
    chk(per == 59, "R8 previous setting kept", per, 59);
    chk(mcc == 27, "R8 previous A kept", mcc, 27);
    run_cfg(9, 9, 0, "R1 ratio B*P+A");
    chk(cfg_err == 0, "R7 flag clears on legal", cfg_err, 0);

    // counter reset, held N=81, A=9
    cnt_rst = 1'b1;
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (div != 0 || mod_ctl != 1) bad++;
    end
    chk(bad == 0, "R6 held during counter reset", bad, 0);
    cnt_rst = 1'b0;
    bad = 0;
    for (int k = 1; k <= 81; k++) begin
      @(negedge clk);
      if (k < 81 && div != 0) bad++;
    end
    chk(bad == 0, "R6 no early pulse", bad, 0);
    chk(div == 1, "R6 first pulse after N edges", div, 1);
    measure(per, mcc);
    chk(per == 81, "R6 period after release", per, 81);

    // pulse width
    chk(div == 1, "R3 pulse present", div, 1);
    @(negedge clk);
    chk(div == 0, "R3 pulse one clock", div, 0);

    summary();
    $finish;
  end
endmodule